// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM whose read and write cycles share one two-stage pipeline, so that reads and writes can follow each other on every clock with no idle cycle on the data bus. The data word is 36 bits, split into four 9-bit byte lanes, and the depth is a parameter. A write presents its address and lane enables on one edge and its data two enabled edges later. A read presents its address on one edge, and its registered data appears after the second enabled edge that follows.

A cycle type is set only on a load edge (load strobe low). On such an edge the part is either selected, and the read/write input picks the type, or not selected, and the cycle is a deselect. On an edge with the load strobe high, the previous type continues at an address supplied by an external burst sequencer. A low-active synchronous clock enable freezes every stage. The output enable gates the data drivers combinationally. The bidirectional data pins are split into a write-data bus, a read-data bus and a drive flag.

Top module: `zbt_sram`

## Requirements
- R1: A write whose address is sampled on enabled edge k takes its data from `wdata` on enabled edge k+2, and no read data is driven in the cycle after that edge.
- R2: During a write, lane i (bits 9i+8..9i) is stored only when `lane_wen_n[i]` is 0. A lane whose enable bit is 1 keeps its old contents.
- R3: Read data for an address sampled on enabled edge k is on `rdata` after enabled edge k+2. `rdata_oe` is 1 in that cycle when `out_en_n` is 0.
- R4: A read issued on the edge right after a write to the same address returns the written lanes merged with the previously stored lanes.
- R5: On an enabled edge with `load_n` = 1, the previous cycle type continues at `burst_addr`, using the `lane_wen_n` sampled on that edge.
- R6: A load edge is a deselect unless `sel_n` = 0, `sel_hi` = 1 and `sel2_n` = 0. A deselect drives no data and writes nothing, two enabled edges later.
- R7: An edge with `load_n` = 1 that follows a deselect is also a deselect.
- R8: While `clk_en_n` = 1, no input is sampled, `wdata` is ignored, and `rdata`, `rdata_oe` and every pipeline stage hold their values.
- R9: `rdata_oe` is 0 whenever `out_en_n` = 1, with no clock involved.
- R10: After reset, `rdata_oe` is 0 and no read or write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Synchronous clock enable, active low |
| sel_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| sel2_n | input | 1 | Second select, active low |
| load_n | input | 1 | Load a new cycle (low) or continue a burst (high) |
| rd_wr | input | 1 | 1 = read, 0 = write (on load edges) |
| lane_wen_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Address for load edges |
| burst_addr | input | AW | Next burst address from the external sequencer |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after its address |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | Data drive flag |

## Verification
A write completing its data slot and a read entering its data slot can fall on consecutive edges to the same address. The most demanding case is a partial-lane write followed at once by a read of that address, where the read must see the merged word. The bench provokes this directly and then through long random mixes of loads, bursts, deselects, output-enable toggles and clock-enable stalls. The stalls land while writes are still waiting for their data. A scoreboard with its own delay-line model of the two stages and a reference array predicts every read word and every cycle's drive flag, and checks them against the ports.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zbt_op_e;
endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode
  import zbt_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             load_n,
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             sel2_n,
  input  logic             rd_wr,
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    burst_addr,
  input  logic [LANES-1:0] lane_wen_n,
  input  zbt_op_e          prev_op,
  output zbt_op_e          nxt_op,
  output logic [AW-1:0]    nxt_addr,
  output logic [LANES-1:0] nxt_wen_n
);
  logic chip_on;

  assign chip_on = !sel_n && sel_hi && !sel2_n;

  always_comb begin
    nxt_wen_n = lane_wen_n;
    if (!load_n) begin
      nxt_addr = addr;
      if (!chip_on)   nxt_op = OP_NONE;
      else if (rd_wr) nxt_op = OP_READ;
      else            nxt_op = OP_WRITE;
    end else begin
      nxt_addr = burst_addr;
      nxt_op   = prev_op;
    end
  end
endmodule

// File: rtl/zbt_lane_mem.sv
module zbt_lane_mem #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [AW-1:0]           acc_addr,
  input  logic [LANES-1:0]        wen_n,
  input  logic [LANES*LANE_W-1:0] wr_word,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !wen_n[g]) begin
        cells[acc_addr] <= wr_word[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[acc_addr];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel_n,
  input  logic                    sel_hi,
  input  logic                    sel2_n,
  input  logic                    load_n,
  input  logic                    rd_wr,
  input  logic [LANES-1:0]        lane_wen_n,
  input  logic                    out_en_n,
  input  logic [AW-1:0]           addr,
  input  logic [AW-1:0]           burst_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DW = LANES * LANE_W;

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic stage_en;
  assign stage_en = !clk_en_n;

  // stage 1: address/control, stage 2: data slot
  zbt_op_e          s1_op_q, s1_op_d, s2_op_q, s2_op_d, dec_op;
  logic [AW-1:0]    s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d, dec_addr;
  logic [LANES-1:0] s1_wen_q, s1_wen_d, s2_wen_q, s2_wen_d, dec_wen;
  logic [DW-1:0]    q_data_q, q_data_d, mem_word;
  logic             q_vld_q, q_vld_d, mem_wr;

  zbt_cmd_decode #(.AW(AW), .LANES(LANES)) u_dec (
    .load_n     (load_n),
    .sel_n      (sel_n),
    .sel_hi     (sel_hi),
    .sel2_n     (sel2_n),
    .rd_wr      (rd_wr),
    .addr       (addr),
    .burst_addr (burst_addr),
    .lane_wen_n (lane_wen_n),
    .prev_op    (s1_op_q),
    .nxt_op     (dec_op),
    .nxt_addr   (dec_addr),
    .nxt_wen_n  (dec_wen)
  );

  assign mem_wr = stage_en && (s2_op_q == OP_WRITE);

  zbt_lane_mem #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk      (clk),
    .wr_en    (mem_wr),
    .acc_addr (s2_addr_q),
    .wen_n    (s2_wen_q),
    .wr_word  (wdata),
    .rd_word  (mem_word)
  );

  always_comb begin
    s1_op_d   = s1_op_q;
    s1_addr_d = s1_addr_q;
    s1_wen_d  = s1_wen_q;
    s2_op_d   = s2_op_q;
    s2_addr_d = s2_addr_q;
    s2_wen_d  = s2_wen_q;
    q_vld_d   = q_vld_q;
    q_data_d  = q_data_q;
    if (stage_en) begin
      s1_op_d   = dec_op;
      s1_addr_d = dec_addr;
      s1_wen_d  = dec_wen;
      s2_op_d   = s1_op_q;
      s2_addr_d = s1_addr_q;
      s2_wen_d  = s1_wen_q;
      q_vld_d   = (s2_op_q == OP_READ);
      if (s2_op_q == OP_READ) q_data_d = mem_word;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_op_q   <= OP_NONE;
      s1_addr_q <= '0;
      s1_wen_q  <= '1;
      s2_op_q   <= OP_NONE;
      s2_addr_q <= '0;
      s2_wen_q  <= '1;
      q_vld_q   <= 1'b0;
      q_data_q  <= '0;
    end else begin
      s1_op_q   <= s1_op_d;
      s1_addr_q <= s1_addr_d;
      s1_wen_q  <= s1_wen_d;
      s2_op_q   <= s2_op_d;
      s2_addr_q <= s2_addr_d;
      s2_wen_q  <= s2_wen_d;
      q_vld_q   <= q_vld_d;
      q_data_q  <= q_data_d;
    end
  end

  assign rdata    = q_data_q;
  assign rdata_oe = q_vld_q && !out_en_n;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
  import zbt_pkg::*;
#(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          load_n,
  input logic          sel_n,
  input logic          sel_hi,
  input logic          sel2_n,
  input logic          out_en_n,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe,
  input zbt_op_e       s1_op,
  input zbt_op_e       s2_op
);
  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_oe);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rdata) && $stable(s1_op) && $stable(s2_op)));

  p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && (sel_n || !sel_hi || sel2_n)) |=> (s1_op == OP_NONE));

  p_burst_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n) |=> (s1_op == $past(s1_op)));

  p_read_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_op == OP_READ) |=> (out_en_n || rdata_oe));

  p_write_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_op != OP_READ) |=> !rdata_oe);
endmodule

bind zbt_sram zbt_sram_chk #(.DW(LANES*LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en_n (clk_en_n),
  .load_n   (load_n),
  .sel_n    (sel_n),
  .sel_hi   (sel_hi),
  .sel2_n   (sel2_n),
  .out_en_n (out_en_n),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .s1_op    (s1_op_q),
  .s2_op    (s2_op_q)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  localparam int AW = 6, LANES = 4, LANE_W = 9, DW = 36, DEPTH = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, clk_en_n, sel_n, sel_hi, sel2_n, load_n, rd_wr, out_en_n;
  logic [LANES-1:0] lane_wen_n;
  logic [AW-1:0]    addr, burst_addr;
  logic [DW-1:0]    wdata, rdata;
  logic             rdata_oe;

  zbt_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_n(sel_n),
    .sel_hi(sel_hi), .sel2_n(sel2_n), .load_n(load_n), .rd_wr(rd_wr),
    .lane_wen_n(lane_wen_n), .out_en_n(out_en_n), .addr(addr),
    .burst_addr(burst_addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  typedef struct {
    bit            vld;
    bit            wr;
    logic [AW-1:0] a;
    logic [3:0]    wen;
    logic [DW-1:0] d;
  } op_t;

  int            n_chk = 0, n_fail = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_q [$];
  op_t           p1, p2;
  bit            exp_drive = 0;
  bit            mon_on = 0;

  function automatic logic [DW-1:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: present data for the op in the data slot, clock, update model
  task automatic tick();
    op_t nw;
    if (!clk_en_n && p2.vld && p2.wr) wdata = p2.d;
    else                              wdata = rnd36();
    @(posedge clk);
    #1;
    if (!clk_en_n) begin
      if (p2.vld && p2.wr) begin
        for (int l = 0; l < LANES; l++)
          if (!p2.wen[l]) ref_mem[p2.a][l*LANE_W +: LANE_W] = p2.d[l*LANE_W +: LANE_W];
      end
      exp_drive = p2.vld && !p2.wr;
      if (exp_drive) exp_q.push_back(ref_mem[p2.a]);
      if (!load_n) begin
        nw.vld = !sel_n && sel_hi && !sel2_n;
        nw.wr  = !rd_wr;
        nw.a   = addr;
      end else begin
        nw.vld = p1.vld;
        nw.wr  = p1.wr;
        nw.a   = burst_addr;
      end
      nw.wen = lane_wen_n;
      nw.d   = rnd36();
      p2 = p1;
      p1 = nw;
    end
  endtask

  task automatic idle_inputs();
    clk_en_n = 0; sel_n = 0; sel_hi = 1; sel2_n = 0; load_n = 0; rd_wr = 1;
    lane_wen_n = 4'hF; out_en_n = 0; addr = '0; burst_addr = '0;
    sel_n = 1;
  endtask

  task automatic op_load(input bit wr, input logic [AW-1:0] a, input logic [3:0] wen);
    clk_en_n = 0; load_n = 0; sel_n = 0; sel_hi = 1; sel2_n = 0;
    rd_wr = !wr; addr = a; lane_wen_n = wen;
    tick();
  endtask

  // monitor: pops expected read words and checks the drive flag each cycle
  always @(negedge clk) begin
    if (mon_on) begin
      check(rdata_oe == (exp_drive && !out_en_n), "R3 R6 R9 drive flag",
            {35'd0, rdata_oe}, {35'd0, exp_drive && !out_en_n});
      if (exp_q.size() > 0 && exp_drive) begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rdata === e, "R1 R2 R4 R5 read word", rdata, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    p1 = '{default: 0};
    p2 = '{default: 0};
    idle_inputs();
    wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) tick();
    // R10: nothing driven and nothing pending after reset
    check(rdata_oe == 1'b0, "R10 reset drive", {35'd0, rdata_oe}, '0);
    mon_on = 1;

    // fill the array through full-word writes (R1)
    for (int i = 0; i < DEPTH; i++) op_load(1, i[AW-1:0], 4'h0);
    // R2 R4: partial write then immediate read of the same address
    op_load(1, 6'd5, 4'b1010);
    op_load(0, 6'd5, 4'hF);
    op_load(1, 6'd9, 4'b0111);
    op_load(0, 6'd9, 4'hF);
    op_load(0, 6'd10, 4'hF);
    // R5: write burst then read burst over the external sequencer address
    op_load(1, 6'd20, 4'h0);
    for (int i = 1; i < 4; i++) begin
      load_n = 1; burst_addr = 6'd20 + i[AW-1:0]; lane_wen_n = i[3:0]; tick();
    end
    op_load(0, 6'd20, 4'hF);
    for (int i = 1; i < 4; i++) begin
      load_n = 1; burst_addr = 6'd20 + i[AW-1:0]; tick();
    end
    // R6 R7: each select pin deselects; burst after deselect stays idle
    op_load(1, 6'd30, 4'h0); sel_n = 1; load_n = 0; tick();
    load_n = 1; burst_addr = 6'd31; lane_wen_n = 4'h0; tick();
    op_load(0, 6'd30, 4'hF); sel_hi = 0; load_n = 0; tick();
    sel_hi = 1; sel2_n = 1; tick();
    sel2_n = 0; op_load(0, 6'd31, 4'hF);
    // R8: stall with a write waiting for its data and a read in flight
    op_load(1, 6'd40, 4'h0);
    op_load(0, 6'd41, 4'hF);
    clk_en_n = 1; @(negedge clk); held = rdata;
    repeat (5) tick();
    check(rdata === held, "R8 stall hold", rdata, held);
    clk_en_n = 0; load_n = 1; burst_addr = 6'd40; tick();
    op_load(0, 6'd40, 4'hF); tick(); tick();
    // R9: output enable removed while a read word is due
    op_load(0, 6'd40, 4'hF); out_en_n = 1; tick(); tick(); out_en_n = 0;

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int s;
      clk_en_n   = ($urandom % 7 == 0);
      load_n     = ($urandom % 3 == 0);
      s          = $urandom % 10;
      sel_n      = (s == 0);
      sel_hi     = (s != 1);
      sel2_n     = (s == 2);
      rd_wr      = $urandom % 2;
      lane_wen_n = $urandom;
      addr       = $urandom;
      burst_addr = $urandom;
      out_en_n   = ($urandom % 9 == 0);
      tick();
    end
    clk_en_n = 0; load_n = 0; sel_n = 1; out_en_n = 0;
    repeat (4) tick();
    check(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    mon_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule